// File: doc/BRIEF.md
# Bus-Invert Transmit/Receive Codec

This block lowers switching activity on a wide parallel bus. The transmit side keeps a register holding the word it last placed on the bus lines. For each new word it compares that word with the register and counts the lines that differ. When more than half of the lines would change, it drives the complement of the word and raises a single extra polarity line. Otherwise it drives the word as it is and leaves the polarity line low. Either way, the data lines never switch on more than half of their wires for any one transfer.

The receive side takes the bus lines and the polarity line and registers a copy. It inverts the received word when polarity is high, which restores the original data. Both halves sit in one top module so they can be instantiated back to back, or split across a link with the bus wires in between. A valid strobe travels with each word through both stages.

Top module: `bus_invert_codec`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero at that edge: `bus_data`, `bus_pol`, `bus_valid`, `out_data` and `out_valid`.
- R2: When `in_valid` is high and more than DATA_W/2 bits of `in_data` differ from the current `bus_data`, the next edge loads `bus_data` with the bitwise complement of `in_data` and sets `bus_pol` to 1.
- R3: When `in_valid` is high and at most DATA_W/2 bits differ, which includes exactly DATA_W/2, the next edge loads `bus_data` with `in_data` unchanged and sets `bus_pol` to 0.
- R4: Each accepted word changes at most DATA_W/2 of the `bus_data` lines. Over any stream of words, the total number of `bus_data` line changes is no greater than the total number of bit changes between consecutive raw input words, with the first word compared against zero.
- R5: The word on `out_data` equals the `in_data` that was accepted two rising edges earlier, whatever the polarity.
- R6: An edge with `in_valid` low leaves `bus_data` and `bus_pol` unchanged and drives `bus_valid` low.
- R7: `bus_valid` is high exactly one edge after `in_valid` was sampled high, and `out_valid` is high exactly one edge after `bus_valid` was high.
- R8: When `bus_valid` is low, `out_data` keeps the last decoded word.
- R9: With DATA_W=8 and `bus_data` at zero, the input 8'hFE is sent as 8'h01 with `bus_pol` set, so exactly one data line changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` for encoding |
| in_data | input | DATA_W | Raw word to transmit |
| bus_data | output | DATA_W | Encoded data lines, registered |
| bus_pol | output | 1 | Polarity line, 1 means the data lines carry the complement |
| bus_valid | output | 1 | High in the cycle after an accepted word |
| out_data | output | DATA_W | Decoded word, registered |
| out_valid | output | 1 | High in the cycle after `bus_valid` |

## Verification
The assertions assume that `in_data` holds a known, stable value at every edge where `in_valid` is high, and that reset is held for at least two edges before the first word. Under those conditions, the two-cycle check from input to output in R5 only refers back to cycles after reset. The bench drives all inputs on the falling edge, holds reset for several cycles at the start and again partway through the run, and never leaves `in_data` unknown. Its random words come from a fixed seed. They are mixed with complements of the current bus value, which forces full inversion, and with words exactly DATA_W/2 bits away, so that the rules for inverting and for keeping the word are both exercised often.

// File: rtl/bic_pkg.sv
package bic_pkg;

  typedef enum logic {
    POL_PLAIN    = 1'b0,
    POL_INVERTED = 1'b1
  } bic_pol_e;

  function automatic int bic_limit(input int width);
    return width / 2;
  endfunction

endpackage

// File: rtl/bic_popcount.sv
module bic_popcount #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] vec,
  output logic [CNT_W-1:0]  ones
);

  logic [CNT_W-1:0] bit_ext [DATA_W];

  for (genvar g = 0; g < DATA_W; g++) begin : g_ext
    assign bit_ext[g] = CNT_W'(vec[g]);
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + bit_ext[i];
    end
  end

endmodule

// File: rtl/bic_encoder.sv
module bic_encoder
  import bic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] enc_data,
  output logic              enc_pol,
  output logic              enc_valid
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int LIMIT = bic_limit(DATA_W);

  logic [DATA_W-1:0] line_q;
  logic [DATA_W-1:0] flip_mask;
  logic [CNT_W-1:0]  flip_cnt;
  bic_pol_e          pol_next;
  bic_pol_e          pol_q;

  assign flip_mask = in_data ^ line_q;

  bic_popcount #(.DATA_W(DATA_W)) i_popcount (
    .vec  (flip_mask),
    .ones (flip_cnt)
  );

  always_comb begin
    if (flip_cnt > CNT_W'(LIMIT)) pol_next = POL_INVERTED;
    else                          pol_next = POL_PLAIN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= '0;
      pol_q     <= POL_PLAIN;
      enc_valid <= 1'b0;
    end else begin
      enc_valid <= in_valid;
      if (in_valid) begin
        pol_q  <= pol_next;
        line_q <= (pol_next == POL_INVERTED) ? ~in_data : in_data;
      end
    end
  end

  assign enc_data = line_q;
  assign enc_pol  = (pol_q == POL_INVERTED);

endmodule

// File: rtl/bic_decoder.sv
module bic_decoder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_pol,
  input  logic              rx_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic              dec_valid
);

  logic [DATA_W-1:0] restored;

  assign restored = rx_data ^ {DATA_W{rx_pol}};

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_data  <= '0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= rx_valid;
      if (rx_valid) dec_data <= restored;
    end
  end

endmodule

// File: rtl/bus_invert_codec.sv
module bus_invert_codec #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_pol,
  output logic              bus_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  bic_encoder #(.DATA_W(DATA_W)) i_encoder (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .enc_data  (bus_data),
    .enc_pol   (bus_pol),
    .enc_valid (bus_valid)
  );

  bic_decoder #(.DATA_W(DATA_W)) i_decoder (
    .clk       (clk),
    .rst       (rst),
    .rx_data   (bus_data),
    .rx_pol    (bus_pol),
    .rx_valid  (bus_valid),
    .dec_data  (out_data),
    .dec_valid (out_valid)
  );

endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_pol,
  input logic              bus_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid
);

  localparam int LIMIT = DATA_W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (bus_data == '0) && !bus_pol && !bus_valid && !out_valid && (out_data == '0)); // R1

  AST_POL_DECISION: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_pol == ($countones($past(in_data) ^ $past(bus_data)) > LIMIT))); // R2

  AST_LINES_MATCH_POL: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_data == (bus_pol ? ~$past(in_data) : $past(in_data)))); // R3

  AST_BOUNDED_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ($countones(bus_data ^ $past(bus_data)) <= LIMIT)); // R4

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == $past(in_data, 2))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> ($stable(bus_data) && $stable(bus_pol))); // R6

  AST_BUS_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> bus_valid); // R7

  AST_OUT_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> out_valid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R8

endmodule

bind bus_invert_codec bic_checker #(.DATA_W(DATA_W)) i_bic_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .bus_data  (bus_data),
  .bus_pol   (bus_pol),
  .bus_valid (bus_valid),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/test_bus_invert_codec.sv
`timescale 1ns/1ps
module test_bus_invert_codec;

  localparam int W = 8;
  localparam int HALF = W / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] bus_data;
  logic         bus_pol;
  logic         bus_valid;
  logic [W-1:0] out_data;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_bus, m_out, m_raw, prev_d;
  logic         m_pol, prev_v;
  longint       raw_total, enc_total;

  always #4 clk = ~clk;

  bus_invert_codec #(.DATA_W(W)) i_bus_invert_codec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .bus_data(bus_data), .bus_pol(bus_pol), .bus_valid(bus_valid),
    .out_data(out_data), .out_valid(out_valid)
  );

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bus = '0; m_pol = 1'b0; m_out = '0; m_raw = '0;
    prev_d = '0; prev_v = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    chk(bus_data == '0, "R1 bus_data", bus_data, 0);
    chk(bus_pol == 1'b0, "R1 bus_pol", bus_pol, 0);
    chk(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
    chk(out_data == '0, "R1 out_data", out_data, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    rst = 1'b0;
  endtask

  task automatic step(input bit v, input logic [W-1:0] d);
    logic [W-1:0] old_bus;
    int flips;
    in_valid = v; in_data = d;
    @(posedge clk);
    @(negedge clk);
    if (prev_v) m_out = prev_d;
    chk(out_valid == prev_v, "R7 out_valid", out_valid, prev_v);
    chk(out_data == m_out, prev_v ? "R5 out_data" : "R8 out_data hold", out_data, m_out);
    old_bus = m_bus;
    if (v) begin
      flips = ones(d ^ m_bus);
      if (flips > HALF) begin m_bus = ~d; m_pol = 1'b1; end
      else begin m_bus = d; m_pol = 1'b0; end
      raw_total += ones(d ^ m_raw);
      m_raw = d;
      enc_total += ones(bus_data ^ old_bus);
      chk(bus_pol == m_pol, flips > HALF ? "R2 pol" : "R3 pol", bus_pol, m_pol);
      chk(bus_data == m_bus, flips > HALF ? "R2 data" : "R3 data", bus_data, m_bus);
      chk(ones(bus_data ^ old_bus) <= HALF, "R4 per-word toggles", ones(bus_data ^ old_bus), HALF);
    end else begin
      chk(bus_data == m_bus && bus_pol == m_pol, "R6 idle hold", {bus_pol, bus_data}, {m_pol, m_bus});
    end
    chk(bus_valid == v, "R7 bus_valid", bus_valid, v);
    prev_v = v; prev_d = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    raw_total = 0; enc_total = 0;
    model_reset();
    do_reset();

    // R9 directed example from an all-zero bus
    step(1'b1, 8'hFE);
    chk(bus_data == 8'h01 && bus_pol == 1'b1, "R9 example", {bus_pol, bus_data}, 9'h101);
    // R3 exactly half the lines differ: no inversion
    step(1'b1, 8'h0E);
    chk(bus_pol == 1'b0, "R3 exact half", bus_pol, 0);
    // R6 R8 idle cycles
    step(1'b0, 8'hAA);
    step(1'b0, 8'h55);
    step(1'b0, 8'h00);
    // R2 all lines would toggle
    step(1'b1, ~m_bus);
    step(1'b1, ~m_bus);
    step(1'b0, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] d;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)       d = W'($urandom);
      else if (sel < 7)  d = ~m_bus;
      else begin
        d = m_bus;
        for (int k = 0; k < HALF; k++) d[k] = ~d[k];
      end
      if (n == 1500) do_reset();
      step($urandom_range(0, 3) != 0, d);
    end
    step(1'b0, '0);
    chk(enc_total <= raw_total, "R4 total toggles", enc_total, raw_total);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule